// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Controller with Software Lock

This block is the host-side write logic of a byte-wide paged nonvolatile memory, built as synchronous logic. The host drives an address, a data byte and three active-low strobes: chip enable, output enable and write enable. The block samples these strobes on the system clock. A small register array stands in for the nonvolatile cells. The data pins are split into `data_in`, `data_out` and an output-enable flag `data_oe`, which a pad ring can merge into one bidirectional bus.

A write opens a load phase. More writes to the same page can follow inside a byte-load window. When that window expires, a programming interval of fixed length starts. At the end of the interval, the loaded bytes are copied into the array. While programming runs, a read returns a status byte in which one bit alternates from read to read, so the host can poll for completion.

A three-write unlock command turns on a persistent write lock. Once the lock is on, only a write that directly follows the same command is stored. Any other write still runs the programming timer, but the array does not change.

Top module: `pgmem_wp_ctrl`

## Requirements
- R1: Reset leaves `data_oe` low, every array byte reading 0x00, the lock disabled, and the controller idle.
- R2: `data_oe` is high exactly when `ce_n` and `oe_n` are low and `we_n` is high. Outside programming, `data_out` then carries the array byte at `addr`.
- R3: A write strobe is the OR of `ce_n` and `we_n`. Its falling edge captures `addr`, and its rising edge captures `data_in`. A byte written this way reads back after the load window and the programming interval have passed.
- R4: Writes that share `addr[14:6]` during one load phase form a page write. `addr[5:0]` picks the byte within the 64-byte page, and the last write to a byte wins.
- R5: Bytes of the page that were not loaded keep their earlier contents.
- R6: Each accepted write restarts a window of LOAD_WIN clock cycles. Until that window expires, reads return the old array data. When it expires, a programming interval of PROG_T cycles begins.
- R7: During a load phase, a write whose `addr[14:6]` differs from the open page is ignored.
- R8: A read during programming returns a status byte with bit 6 as the toggle and all other bits 0. The first read returns 0x00, and bit 6 inverts after each completed read. After programming, reads return true data.
- R9: In the idle state, writing 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 turns the lock on. These three bytes are never stored, and the next write is permitted.
- R10: While the lock is on, a write not preceded by the command runs the load window and the programming interval (status is visible) but leaves the array unchanged.
- R11: While the lock is on, a byte or page write preceded by the command is stored.
- R12: A write that breaks the command part-way aborts the command and is handled as an ordinary write.
- R13: Once on, the lock stays on across operations until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 15 | Byte address |
| data_in | input | 8 | Write data from host |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| data_out | output | 8 | Read data or programming status |
| data_oe | output | 1 | Drive enable for the data pins |

## Verification
The bench applies these write patterns:
- Single byte writes, which show the basic capture and programming path.
- Page writes that load the top and bottom byte of a page, with a neighbouring byte pre-set. These separate masked programming from a whole-page copy.
- A page write with a stray write to another page mixed in, which shows that the foreign page is rejected rather than a new page being opened.
- The unlock command in complete, aborted and omitted forms. These distinguish a command from ordinary data, a blocked write from a permitted one, and the lock's persistence from its clearing by reset.

Status polling is sampled inside the load window and inside the programming interval, so the point where reads switch to status can be pinned down.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int ADDR_W    = 15;
    localparam int DATA_W    = 8;
    localparam int PAGE_BITS = 6;
    localparam int TOG_BIT   = 6;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [DATA_W-1:0] KEY_DATA_1 = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_DATA_2 = 8'h55;
    localparam logic [DATA_W-1:0] KEY_DATA_3 = 8'hA0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } wp_state_e;

    typedef struct packed {
        logic [ADDR_W-PAGE_BITS-1:0] page;
        logic [PAGE_BITS-1:0]        offs;
    } wp_addr_t;

    function automatic logic key_match(input logic [1:0] step,
                                       input logic [ADDR_W-1:0] a,
                                       input logic [DATA_W-1:0] d);
        case (step)
            2'd0:    return (a == KEY_ADDR_A) && (d == KEY_DATA_1);
            2'd1:    return (a == KEY_ADDR_B) && (d == KEY_DATA_2);
            2'd2:    return (a == KEY_ADDR_A) && (d == KEY_DATA_3);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] status_byte(input logic tog);
        logic [DATA_W-1:0] s;
        s = '0;
        s[TOG_BIT] = tog;
        return s;
    endfunction

endpackage

// File: rtl/wp_edge_det.sv
module wp_edge_det #(
    parameter bit RISING = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe_n;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = !prev_q && strobe_n;
        end else begin : g_fall
            assign pulse = prev_q && !strobe_n;
        end
    endgenerate
endmodule

// File: rtl/wp_key_seq.sv
module wp_key_seq
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [DATA_W-1:0] evt_data,
    output logic              key_hit,
    output logic              key_done
);
    logic [1:0] step_q;
    logic       match;

    always_comb begin
        match    = key_match(step_q, evt_addr, evt_data);
        key_hit  = evt_valid && match;
        key_done = key_hit && (step_q == 2'd2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= 2'd0;
        end else if (evt_valid) begin
            step_q <= (match && step_q != 2'd2) ? step_q + 2'd1 : 2'd0;
        end
    end
endmodule

// File: rtl/wp_page_buf.sv
module wp_page_buf
    import wp_pkg::*;
#(
    parameter int OFFS_W = PAGE_BITS,
    localparam int SLOTS = 1 << OFFS_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear,
    input  logic                          load,
    input  logic [OFFS_W-1:0]             idx,
    input  logic [DATA_W-1:0]             data,
    output logic [SLOTS-1:0]              mask,
    output logic [SLOTS-1:0][DATA_W-1:0]  bytes
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '0;
            bytes <= '0;
        end else begin
            if (clear) mask <= '0;
            if (load) begin
                mask[idx]  <= 1'b1;
                bytes[idx] <= data;
            end
        end
    end
endmodule

// File: rtl/pgmem_wp_ctrl.sv
module pgmem_wp_ctrl
    import wp_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int LOAD_WIN  = 8,
    parameter int PROG_T    = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    localparam int PAGE_SZ   = 1 << PAGE_BITS;
    localparam int PG_IDX_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int MEM_AW    = PAGE_BITS + PG_IDX_W;
    localparam int MEM_DEPTH = 1 << MEM_AW;
    localparam int WIN_W     = $clog2(LOAD_WIN + 1);
    localparam int PT_W      = $clog2(PROG_T + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOAD_WIN - 1);
    localparam logic [PT_W-1:0]  PT_LAST  = PT_W'(PROG_T - 1);

    logic wr_n, rd_n, wr_fall, wr_rise, rd_rise;
    assign wr_n = ce_n | we_n;
    assign rd_n = ce_n | oe_n;

    wp_edge_det #(.RISING(1'b0)) u_wr_fall (.clk(clk), .rst(rst), .strobe_n(wr_n), .pulse(wr_fall));
    wp_edge_det #(.RISING(1'b1)) u_wr_rise (.clk(clk), .rst(rst), .strobe_n(wr_n), .pulse(wr_rise));
    wp_edge_det #(.RISING(1'b1)) u_rd_rise (.clk(clk), .rst(rst), .strobe_n(rd_n), .pulse(rd_rise));

    wp_state_e             state_q;
    wp_addr_t              alat_q;
    logic [ADDR_W-PAGE_BITS-1:0] page_q;
    logic                  sdp_q, armed_q, permit_q, tog_q;
    logic [WIN_W-1:0]      win_q;
    logic [PT_W-1:0]       pcnt_q;
    logic [DATA_W-1:0]     mem_q [MEM_DEPTH];

    logic idle_evt, key_hit, key_done, start_load, load_more;
    logic [PAGE_SZ-1:0]             pg_mask;
    logic [PAGE_SZ-1:0][DATA_W-1:0] pg_bytes;

    assign idle_evt   = wr_rise && (state_q == ST_IDLE);
    assign start_load = idle_evt && !key_hit;
    assign load_more  = wr_rise && (state_q == ST_LOAD) && (alat_q.page == page_q);

    wp_key_seq u_key (
        .clk(clk), .rst(rst), .evt_valid(idle_evt),
        .evt_addr(alat_q), .evt_data(data_in),
        .key_hit(key_hit), .key_done(key_done)
    );

    wp_page_buf #(.OFFS_W(PAGE_BITS)) u_buf (
        .clk(clk), .rst(rst), .clear(start_load),
        .load(start_load || load_more), .idx(alat_q.offs), .data(data_in),
        .mask(pg_mask), .bytes(pg_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            alat_q   <= '0;
            page_q   <= '0;
            sdp_q    <= 1'b0;
            armed_q  <= 1'b0;
            permit_q <= 1'b0;
            tog_q    <= 1'b0;
            win_q    <= '0;
            pcnt_q   <= '0;
            for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (wr_fall) alat_q <= addr;
            unique case (state_q)
                ST_IDLE: begin
                    if (key_done) begin
                        sdp_q   <= 1'b1;
                        armed_q <= 1'b1;
                    end
                    if (start_load) begin
                        state_q  <= ST_LOAD;
                        page_q   <= alat_q.page;
                        permit_q <= !sdp_q || armed_q;
                        armed_q  <= 1'b0;
                        win_q    <= '0;
                    end
                end
                ST_LOAD: begin
                    if (load_more) begin
                        win_q <= '0;
                    end else if (win_q == WIN_LAST) begin
                        state_q <= ST_PROG;
                        pcnt_q  <= '0;
                        tog_q   <= 1'b0;
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (rd_rise) tog_q <= ~tog_q;
                    if (pcnt_q == PT_LAST) begin
                        state_q <= ST_IDLE;
                        if (permit_q) begin
                            for (int i = 0; i < PAGE_SZ; i++) begin
                                if (pg_mask[i])
                                    mem_q[{page_q[PG_IDX_W-1:0], PAGE_BITS'(i)}] <= pg_bytes[i];
                            end
                        end
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign data_oe  = !ce_n && !oe_n && we_n;
    assign data_out = (state_q == ST_PROG) ? status_byte(tog_q) : mem_q[addr[MEM_AW-1:0]];
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk
    import wp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out,
    input wp_state_e         state_q,
    input logic              sdp_q,
    input logic              wr_rise
);
    // R1
    rst_lock_clear_chk: assert property (@(posedge clk) rst |=> !sdp_q);

    // R2
    hiz_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> !data_oe);

    // R6
    load_leads_prog_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD) |=> (state_q != ST_IDLE));

    // R7
    no_load_in_prog_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG) |=> (state_q != ST_LOAD));

    // R8
    status_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && data_oe) |-> (data_out[7] == 1'b0 && data_out[5:0] == 6'd0));

    // R9
    lock_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdp_q) |-> $past(wr_rise));

    // R13
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sdp_q |=> sdp_q);
endmodule

bind pgmem_wp_ctrl wp_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n),
    .data_oe(data_oe), .data_out(data_out),
    .state_q(state_q), .sdp_q(sdp_q), .wr_rise(wr_rise)
);

// File: tb/pgmem_wp_ctrl_tb_top.sv
module pgmem_wp_ctrl_tb_top;
    localparam int LW = 8;
    localparam int PT = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0]  data_out;
    logic        data_oe;

    always #10 clk = ~clk;

    pgmem_wp_ctrl #(.NUM_PAGES(4), .LOAD_WIN(LW), .PROG_T(PT)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .data_in(data_in),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .data_out(data_out), .data_oe(data_oe)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    byte unsigned ref_mem [256];
    bit ref_sdp, ref_armed, in_load, ld_permit;
    int seq, pg;
    int qa[$], qd[$];

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit key_ok(int step, int a, int d);
        case (step)
            0: return a == 'h5555 && d == 'hAA;
            1: return a == 'h2AAA && d == 'h55;
            2: return a == 'h5555 && d == 'hA0;
            default: return 0;
        endcase
    endfunction

    task automatic model_clear();
        foreach (ref_mem[i]) ref_mem[i] = 0;
        ref_sdp = 0; ref_armed = 0; in_load = 0; ld_permit = 0; seq = 0; pg = 0;
        qa.delete(); qd.delete();
    endtask

    task automatic model_write(int a, int d);
        if (!in_load) begin
            if (key_ok(seq, a, d)) begin
                seq++;
                if (seq == 3) begin ref_sdp = 1; ref_armed = 1; seq = 0; end
                return;
            end
            seq = 0; in_load = 1; pg = a >> 6;
            ld_permit = !ref_sdp || ref_armed; ref_armed = 0;
            qa.push_back(a); qd.push_back(d);
        end else if ((a >> 6) == pg) begin
            qa.push_back(a); qd.push_back(d);
        end
    endtask

    task automatic bus_write(int a, int d);
        addr = 15'(a); data_in = 8'(d); ce_n = 0; we_n = 0;
        @(negedge clk);
        we_n = 1; ce_n = 1;
        @(negedge clk);
        model_write(a, d);
    endtask

    task automatic bus_read(int a, output int val);
        addr = 15'(a); ce_n = 0; oe_n = 0;
        @(posedge clk); #2;
        val = data_out;
        @(negedge clk);
        oe_n = 1; ce_n = 1;
        @(negedge clk);
    endtask

    task automatic read_ref(string tag, int a);
        int v;
        bus_read(a, v);
        check(tag, v, ref_mem[a & 255]);
    endtask

    task automatic settle();
        repeat (LW + PT + 6) @(negedge clk);
        if (in_load && ld_permit)
            foreach (qa[i]) ref_mem[qa[i] & 255] = byte'(qd[i]);
        qa.delete(); qd.delete(); in_load = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (4) @(negedge clk);
        model_clear();
        rst = 0;
        @(negedge clk);
    endtask

    // per-clock comparison against the reference
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            check("R2 drive enable", int'(data_oe), int'(!ce_n && !oe_n && we_n));
            if (data_oe && !in_load)
                check("R2 read data", data_out, ref_mem[addr & 255]);
        end
    end

    initial begin
        repeat (200000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int v;
        model_clear();
        do_reset();

        // R1: reset state
        check("R1 oe after reset", int'(data_oe), 0);
        bus_read('h0000, v); check("R1 cell 0x000", v, 0);
        bus_read('h00C3, v); check("R1 cell 0x0C3", v, 0);

        // R3: single byte write
        bus_write('h0105, 'h3C); settle();
        bus_read('h0105, v); check("R3 byte write", v, 'h3C);

        // R4 / R5: page write with untouched neighbour
        bus_write('h0090, 'h77); settle();
        bus_write('h0080, 'h11);
        bus_write('h0081, 'h22);
        bus_write('h00BF, 'h33);
        bus_write('h0081, 'h2B);
        settle();
        bus_read('h0080, v); check("R4 page first", v, 'h11);
        bus_read('h0081, v); check("R4 page rewrite", v, 'h2B);
        bus_read('h00BF, v); check("R4 page last", v, 'h33);
        bus_read('h0090, v); check("R5 untouched byte", v, 'h77);

        // R7: foreign page write during load ignored
        bus_write('h0040, 'h5A);
        bus_write('h00C1, 'h99);
        bus_write('h0041, 'hA5);
        settle();
        bus_read('h00C1, v); check("R7 foreign page", v, 0);
        bus_read('h0041, v); check("R7 same page kept", v, 'hA5);

        // R6 / R8: window, status toggle, then true data
        bus_write('h0003, 'h81);
        bus_read('h0003, v); check("R6 old data in window", v, 0);
        repeat (LW + 3) @(negedge clk);
        bus_read('h0003, v); check("R8 status first", v, 'h00);
        bus_read('h0003, v); check("R8 status second", v, 'h40);
        bus_read('h0003, v); check("R8 status third", v, 'h00);
        settle();
        bus_read('h0003, v); check("R8 true data after", v, 'h81);

        // R12: aborted command is an ordinary write
        bus_write('h5555, 'hAA);
        bus_write('h0020, 'h33);
        settle();
        bus_read('h0020, v); check("R12 aborted key write", v, 'h33);
        read_ref("R12 key byte not stored", 'h5555);

        // R9: unlock command then permitted write
        bus_write('h5555, 'hAA);
        bus_write('h2AAA, 'h55);
        bus_write('h5555, 'hA0);
        bus_write('h0010, 'h66);
        settle();
        bus_read('h0010, v); check("R9 armed write", v, 'h66);
        bus_read('h5555, v); check("R9 cmd not stored A", v, 0);
        bus_read('h2AAA, v); check("R9 cmd not stored B", v, 0);

        // R10: locked write runs timer, no change
        bus_write('h0010, 'h99);
        repeat (LW + 3) @(negedge clk);
        bus_read('h0010, v); check("R10 timer status", v, 'h00);
        settle();
        bus_read('h0010, v); check("R10 array unchanged", v, 'h66);

        // R11: unlocked page write
        bus_write('h5555, 'hAA);
        bus_write('h2AAA, 'h55);
        bus_write('h5555, 'hA0);
        bus_write('h0011, 'h12);
        bus_write('h0012, 'h34);
        settle();
        bus_read('h0011, v); check("R11 unlocked byte 0", v, 'h12);
        bus_read('h0012, v); check("R11 unlocked byte 1", v, 'h34);

        // R13: lock persists
        bus_write('h0012, 'hFF); settle();
        bus_read('h0012, v); check("R13 lock persists", v, 'h34);

        // R1 / R13: reset clears lock
        do_reset();
        bus_write('h0013, 'h5C); settle();
        bus_read('h0013, v); check("R13 reset clears lock", v, 'h5C);
        bus_read('h0012, v); check("R1 array cleared", v, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule